// File: doc/BRIEF.md
# Multiplexed GPIO Port Controller

This block controls one bank of general-purpose pins through a small word-addressed register interface. Each pin is either under GPIO control or handed to one of two on-chip peripheral functions. Under GPIO control the block supplies the pin's output level and drive enable. The pin can also be made open-drain, which is modelled as a drive-enable that is active only for a low level. Pull-up and an input deglitch filter are separate per-pin settings.

Every per-pin setting has three word addresses. The first sets bits: a 1 written there sets the setting for that pin. The second clears bits: a 1 written there clears it. The third reads the current value back. In both write registers a 0 bit leaves the pin untouched, so software can change any set of pins without a read-modify-write.

Pin inputs are synchronised and, where enabled, filtered. The resulting level is readable for every pin. Any change of that level, rising or falling, is latched into a change-status word. Reading the change-status word clears it. One interrupt output is high while any latched bit is also enabled in the interrupt mask.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every pin is under GPIO control (GPIO status word reads all ones) with pull-up on. Output enable, filter, open-drain, interrupt mask, output data and peripheral select all read zero, and the change-status word reads zero. Peripheral select is 0 for peripheral A and 1 for peripheral B.
- R2: Each setting k (0 GPIO, 1 output enable, 2 pull-up, 3 filter, 4 open-drain, 5 interrupt mask, 6 output data, 7 peripheral select) has three word addresses. Writing 1s at 3k sets the matching bits. Writing 1s at 3k+1 clears them. Bits written as 0 keep their value, and 3k+2 reads the setting back. Bit n is pin n.
- R3: A pin under GPIO control drives its output-data bit on pad_out_o and its output-enable bit on pad_oe_o.
- R4: A pin with GPIO control cleared takes pad output and enable from peripheral A when its select bit is 0 and from peripheral B when it is 1. Address 21 selects B and address 22 selects A.
- R5: The peripheral-select bit has no effect on a pin that is under GPIO control.
- R6: With open-drain set, a pin never drives high. A source level of 1 releases the pad (enable 0), and a source level of 0 drives low while the source enable is 1.
- R7: Address 24 returns the sampled level of every pin whatever its direction. Without the filter a pad change is visible there three clock edges later.
- R8: With the filter set, a pad level is accepted only after two equal consecutive synchronised samples. A pulse one clock wide changes neither the level word nor the change status.
- R9: Address 25 latches both rising and falling level changes per pin, and a read of it clears every latched bit.
- R10: irq_o is high exactly while some change-status bit and its interrupt-mask bit are both 1, and stays low with the mask at zero.
- R11: A change that reaches the status in the same cycle as a clearing read of address 25 is kept and is returned by the next read.
- R12: pad_pu_o reflects the pull-up setting of every pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears the change status at address 25) |
| addr_i | input | 5 | Word address |
| wdata_i | input | NPIN | Write data, bit n for pin n |
| rdata_o | output | NPIN | Read data for addr_i (combinational) |
| pad_in_i | input | NPIN | Pad input levels |
| pad_out_o | output | NPIN | Pad output levels |
| pad_oe_o | output | NPIN | Pad drive enables |
| pad_pu_o | output | NPIN | Pull-up enables |
| pa_out_i | input | NPIN | Peripheral A output levels |
| pa_oe_i | input | NPIN | Peripheral A drive enables |
| pb_out_i | input | NPIN | Peripheral B output levels |
| pb_oe_i | input | NPIN | Peripheral B drive enables |
| irq_o | output | 1 | Aggregated pin-change interrupt |

## Verification
The bench builds the block with the default of 32 pins, so every register word is full width. Pins in the upper byte are handed to the peripherals while pins in the lowest byte act as GPIO outputs. This puts GPIO, peripheral-A, peripheral-B and open-drain drive side by side in one output word. With the full bank, a single pad pattern moves many pins at once, so the level word and the latched change status can be checked across all bits together. Separate pins then isolate the filter, the interrupt mask and the change that coincides with a clearing read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned CFG_NUM  = 8;
  // setting index k: set at 3k, clear at 3k+1, status at 3k+2
  localparam int unsigned CFG_GPIO = 0;
  localparam int unsigned CFG_OE   = 1;
  localparam int unsigned CFG_PU   = 2;
  localparam int unsigned CFG_FLT  = 3;
  localparam int unsigned CFG_OD   = 4;
  localparam int unsigned CFG_IRQ  = 5;
  localparam int unsigned CFG_DOUT = 6;
  localparam int unsigned CFG_SEL  = 7;
  localparam logic [CFG_NUM-1:0] CFG_RST_ONES = 8'b0000_0101;
  localparam logic [ADDR_W-1:0] ADDR_LVL = 5'd24;
  localparam logic [ADDR_W-1:0] ADDR_CHG = 5'd25;
endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int unsigned W      = 32,
  parameter logic        RST_ONE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= {W{RST_ONE}};
    else         q_q <= (q_q | set_i) & ~clr_i;
  end
  assign q_o = q_q;

  a_r2_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i & ~clr_i) != '0) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  a_r2_clr_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && clr_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] pad_i,
  input  logic [NPIN-1:0] flt_i,
  output logic [NPIN-1:0] lvl_o
);
  logic [NPIN-1:0] s1_q, s2_q, p_q, lvl_q, hold;

  // filtered pins hold while the last two samples disagree
  assign hold = flt_i & (s2_q ^ p_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= '0;
      s2_q  <= '0;
      p_q   <= '0;
      lvl_q <= '0;
    end else begin
      s1_q  <= pad_i;
      s2_q  <= s1_q;
      p_q   <= s2_q;
      lvl_q <= (lvl_q & hold) | (s2_q & ~hold);
    end
  end
  assign lvl_o = lvl_q;

  a_r8_filter_two_samples: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(flt_i) & (lvl_o ^ $past(lvl_o)) & ($past(s2_q) ^ $past(p_q))) == '0));
endmodule

// File: rtl/gpio_chg_latch.sv
module gpio_chg_latch #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] lvl_i,
  input  logic            clr_i,
  input  logic [NPIN-1:0] imr_i,
  output logic [NPIN-1:0] sts_o,
  output logic            irq_o
);
  logic [NPIN-1:0] prev_q, sts_q, chg;

  assign chg = lvl_i ^ prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      sts_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      sts_q  <= (clr_i ? '0 : sts_q) | chg;
    end
  end
  assign sts_o = sts_q;
  assign irq_o = |(sts_q & imr_i);

  a_r11_edge_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg != '0) |=> ((sts_q & $past(chg)) == $past(chg)));
  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ((sts_q & $past(sts_q & ~chg)) == '0));
  a_r10_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr_i == '0) |-> !irq_o);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int unsigned NPIN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NPIN-1:0] gpio_i,
  input  logic [NPIN-1:0] sel_b_i,
  input  logic [NPIN-1:0] od_i,
  input  logic [NPIN-1:0] oe_i,
  input  logic [NPIN-1:0] dout_i,
  input  logic [NPIN-1:0] pa_out_i,
  input  logic [NPIN-1:0] pa_oe_i,
  input  logic [NPIN-1:0] pb_out_i,
  input  logic [NPIN-1:0] pb_oe_i,
  output logic [NPIN-1:0] pad_out_o,
  output logic [NPIN-1:0] pad_oe_o
);
  logic [NPIN-1:0] per_out, per_oe, src_out, src_oe;

  assign per_out = (sel_b_i & pb_out_i) | (~sel_b_i & pa_out_i);
  assign per_oe  = (sel_b_i & pb_oe_i)  | (~sel_b_i & pa_oe_i);
  assign src_out = (gpio_i & dout_i) | (~gpio_i & per_out);
  assign src_oe  = (gpio_i & oe_i)   | (~gpio_i & per_oe);
  // open-drain: high level releases the pad
  assign pad_oe_o  = src_oe & ~(od_i & src_out);
  assign pad_out_o = src_out & ~od_i;

  a_r6_od_low_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_out_o & od_i) == '0);
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPIN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPIN-1:0]   wdata_i,
  output logic [NPIN-1:0]   rdata_o,
  input  logic [NPIN-1:0]   pad_in_i,
  output logic [NPIN-1:0]   pad_out_o,
  output logic [NPIN-1:0]   pad_oe_o,
  output logic [NPIN-1:0]   pad_pu_o,
  input  logic [NPIN-1:0]   pa_out_i,
  input  logic [NPIN-1:0]   pa_oe_i,
  input  logic [NPIN-1:0]   pb_out_i,
  input  logic [NPIN-1:0]   pb_oe_i,
  output logic              irq_o
);
  logic [CFG_NUM-1:0][NPIN-1:0] cfg;
  logic [NPIN-1:0] lvl, chg_sts;
  logic            chg_clr;

  for (genvar k = 0; k < CFG_NUM; k++) begin : g_cfg
    logic [NPIN-1:0] set_v, clr_v;
    assign set_v = (wr_en_i && addr_i == ADDR_W'(3*k))     ? wdata_i : '0;
    assign clr_v = (wr_en_i && addr_i == ADDR_W'(3*k + 1)) ? wdata_i : '0;
    gpio_setclr_reg #(.W(NPIN), .RST_ONE(CFG_RST_ONES[k])) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v),
      .clr_i (clr_v),
      .q_o   (cfg[k])
    );
  end

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pad_i (pad_in_i),
    .flt_i (cfg[CFG_FLT]),
    .lvl_o (lvl)
  );

  assign chg_clr = rd_en_i && (addr_i == ADDR_CHG);

  gpio_chg_latch #(.NPIN(NPIN)) u_chg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lvl),
    .clr_i (chg_clr),
    .imr_i (cfg[CFG_IRQ]),
    .sts_o (chg_sts),
    .irq_o (irq_o)
  );

  gpio_pin_mux #(.NPIN(NPIN)) u_mux (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .gpio_i   (cfg[CFG_GPIO]),
    .sel_b_i  (cfg[CFG_SEL]),
    .od_i     (cfg[CFG_OD]),
    .oe_i     (cfg[CFG_OE]),
    .dout_i   (cfg[CFG_DOUT]),
    .pa_out_i (pa_out_i),
    .pa_oe_i  (pa_oe_i),
    .pb_out_i (pb_out_i),
    .pb_oe_i  (pb_oe_i),
    .pad_out_o(pad_out_o),
    .pad_oe_o (pad_oe_o)
  );

  assign pad_pu_o = cfg[CFG_PU];

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_LVL) rdata_o = lvl;
    else if (addr_i == ADDR_CHG) rdata_o = chg_sts;
    else begin
      for (int k = 0; k < CFG_NUM; k++) begin
        if (addr_i == ADDR_W'(3*k + 2)) rdata_o = cfg[k];
      end
    end
  end

  a_r10_irq_needs_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((chg_sts & cfg[CFG_IRQ]) != '0));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
  localparam int NPIN = 32;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [NPIN-1:0] wdata = '0, rdata;
  logic [NPIN-1:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic [NPIN-1:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
  logic irq;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  item_t sb[$];

  always #10 clk = ~clk;

  gpio_port_ctrl #(.NPIN(NPIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu),
    .pa_out_i(pa_out), .pa_oe_i(pa_oe), .pb_out_i(pb_out), .pb_oe_i(pb_oe),
    .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each read against the queued expectation mid-cycle
  always @(negedge clk) begin
    if (rd_en) begin
      item_t it;
      if (sb.size() == 0) chk("read without expectation", rdata, 32'hx);
      else begin
        it = sb.pop_front();
        chk(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    sb.push_back(it);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] base;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    rd(5'd2,  32'hFFFF_FFFF, "R1 gpio status");
    rd(5'd5,  32'h0, "R1 oe status");
    rd(5'd8,  32'hFFFF_FFFF, "R1 pull-up status");
    rd(5'd11, 32'h0, "R1 filter status");
    rd(5'd14, 32'h0, "R1 open-drain status");
    rd(5'd17, 32'h0, "R1 irq mask");
    rd(5'd20, 32'h0, "R1 dout status");
    rd(5'd23, 32'h0, "R1 select status");
    rd(5'd25, 32'h0, "R1 change status");
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R12 pad_pu reset", pad_pu, 32'hFFFF_FFFF);

    // R2 set/clear with write-one semantics
    wr(5'd3, 32'h0000_00FF);
    wr(5'd4, 32'h0000_000F);
    rd(5'd5, 32'h0000_00F0, "R2 oe set then clear");
    wr(5'd3, 32'h0);
    wr(5'd4, 32'h0);
    rd(5'd5, 32'h0000_00F0, "R2 zero writes hold");
    wr(5'd7, 32'hFFFF_0000);
    rd(5'd8, 32'h0000_FFFF, "R2 pull-up clear");
    chk("R12 pad_pu follows", pad_pu, 32'h0000_FFFF);

    // R3 GPIO drive
    wr(5'd18, 32'h0000_00A5);
    wr(5'd19, 32'h0000_0005);
    rd(5'd20, 32'h0000_00A0, "R3 dout status");
    chk("R3 pad_oe", pad_oe, 32'h0000_00F0);
    chk("R3 pad_out", pad_out, 32'h0000_00A0);

    // R5 select ignored on GPIO pin 7
    wr(5'd21, 32'h0000_0080);
    rd(5'd23, 32'h0000_0080, "R5 select status");
    chk("R5 pad_out pin7 stays gpio", pad_out, 32'h0000_00A0);

    // R4 peripheral multiplexing on pins 24,25
    pa_out = 32'hFFFF_FFFF; pa_oe = 32'hFFFF_FFFF;
    pb_out = 32'h0;         pb_oe = 32'hFFFF_FFFF;
    wr(5'd1, 32'h0300_0000);
    wr(5'd21, 32'h0200_0000);
    rd(5'd2, 32'hFCFF_FFFF, "R4 gpio status");
    chk("R4 pad_out A/B", pad_out, 32'h0100_00A0);
    chk("R4 pad_oe periph", pad_oe, 32'h0300_00F0);
    wr(5'd22, 32'h0200_0000);
    chk("R4 back to A", pad_out, 32'h0300_00A0);

    // R6 open-drain on pin 5 (dout 1 -> released)
    wr(5'd12, 32'h0000_0020);
    chk("R6 od high released", pad_oe, 32'h0300_00D0);
    wr(5'd19, 32'h0000_0020);
    chk("R6 od low driven oe", pad_oe, 32'h0300_00F0);
    chk("R6 od low driven out", pad_out, 32'h0300_0080);

    // R7 level readback regardless of direction
    base = 32'h1234_5678;
    pad_in = base;
    settle(4);
    rd(5'd24, base, "R7 level word");
    rd(5'd25, base, "R9 all changes latched");
    rd(5'd25, 32'h0, "R9 read cleared");
    chk("R10 masked irq low", {31'd0, irq}, 32'h0);

    // R9/R10 both edges on pin 0 with mask
    wr(5'd15, 32'h0000_0001);
    base = base | 32'h1;
    pad_in = base;
    settle(5);
    chk("R10 irq on rise", {31'd0, irq}, 32'h1);
    rd(5'd25, 32'h0000_0001, "R9 rising latched");
    chk("R10 irq cleared", {31'd0, irq}, 32'h0);
    base = base & ~32'h1;
    pad_in = base;
    settle(5);
    chk("R10 irq on fall", {31'd0, irq}, 32'h1);
    rd(5'd25, 32'h0000_0001, "R9 falling latched");
    wr(5'd16, 32'h0000_0001);
    base = base | 32'h2;
    pad_in = base;
    settle(5);
    chk("R10 unmasked pin no irq", {31'd0, irq}, 32'h0);
    rd(5'd25, 32'h0000_0002, "R9 pin1 latched");

    // R8 filter on pin 8, pin 9 unfiltered
    wr(5'd9, 32'h0000_0100);
    @(posedge clk); #1;
    pad_in = base ^ 32'h0000_0300;
    @(posedge clk); #1;
    pad_in = base;
    settle(6);
    rd(5'd24, base, "R8 short pulse rejected in level");
    rd(5'd25, 32'h0000_0200, "R8 filtered pin no change, unfiltered pin latched");
    base = base | 32'h0000_0100;
    pad_in = base;
    settle(6);
    rd(5'd24, base, "R8 held level accepted");
    rd(5'd25, 32'h0000_0100, "R8 accepted change latched");

    // R11 change arriving with a clearing read
    @(posedge clk); #1;
    base = base | 32'h4;
    pad_in = base;
    repeat (3) @(posedge clk);
    #1;
    begin
      item_t it;
      it.exp = 32'h0; it.tag = "R11 coincident read";
      sb.push_back(it);
      rd_en = 1'b1; addr = 5'd25;
      @(posedge clk); #1;
      rd_en = 1'b0;
    end
    rd(5'd25, 32'h0000_0004, "R11 change kept");

    settle(2);
    chk("scoreboard drained", sb.size(), 32'd0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule